// File: doc/BRIEF.md
# Flash Device Bus Controller with Reset Sequencer

This block is the control core of a parallel NOR-style flash device. It takes the active-low chip-select, read-strobe, write-strobe, device-reset and write-protect pins. It decides when the 16-bit data bus is driven and what is driven onto it: array data, an identifier code, or the status byte. Command writes select the read mode or start an embedded operation. An erase, a word write and a lock clear are each modelled as a fixed-length busy interval, and a ready/busy pin reports that interval.

The device-reset pin is filtered against a minimum low time. A qualified reset aborts any running operation, and the ready/busy pin is held low until the reset is released. On release the block restores read-array mode, loads the status byte with 0x80 and sets every block lock bit. It then enforces two separate wake-up windows: one before reads are driven and one before command writes are accepted. A host ties the reset pin to its own system reset, so the processor always fetches array data when it comes out of reset.

Top module: `nvm_bus_ctrl`

## Requirements
- R1: After the chip reset `rst_n` is released, the block is in read-array mode: with ce_n=0, oe_n=0 and we_n=1 the bus carries `arr_data`, with no command written first.
- R2: `dq_oe` is high only when ce_n=0, oe_n=0, we_n=1, rst_pin_n=1, no qualified reset is in progress and the read wake-up window has ended. A cycle with ce_n=0 and we_n=0 never drives the bus.
- R3: With oe_n=1, `dq_oe` is 0 and `dq_out` is all zeros.
- R4: With ce_n=1, `dq_oe` is 0 whatever the level of oe_n (standby).
- R5: An embedded operation keeps `ry_by` low for exactly OP_CYCLES clock cycles after the accepting edge, even if ce_n is held high for that whole time.
- R6: A low pulse on rst_pin_n that spans fewer than RST_MIN rising clock edges is ignored: a running operation continues, lock bits keep their values, and no wake-up window starts.
- R7: At the edge where a qualified reset is released, the mode returns to read-array, the status byte becomes 0x80 and all NUM_BLOCKS bits of `lock_bits` become 1.
- R8: A qualified reset (rst_pin_n low for RST_MIN edges) during an operation ends that operation, and `ry_by` stays 0 until rst_pin_n is sampled high again.
- R9: For RD_WAKE cycles after reset release, `dq_oe` stays 0. Reads are driven again from the following cycle.
- R10: A command write (ce_n=0, we_n=0) accepted fewer than WR_WAKE cycles after reset release has no effect, and `cmd_ignored` is 1 in the following cycle only.
- R11: Command byte 0xFF selects array reads, 0x90 selects identifier reads (ID_CODE on the bus), and 0x70 selects status reads ({8'h00, status}). Status bit 7 is 1 when idle and 0 while busy, and the other status bits are 0.
- R12: Command bytes 0x20 (erase) and 0x40 (word write) start an operation and switch to status reads. 0x60 does the same and also clears every lock bit, but only when wp_n=1; with wp_n=0 it is ignored. Any start command is ignored while an operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output/read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| rst_pin_n | input | 1 | Device reset pin, active low, sampled on clk |
| wp_n | input | 1 | Write protect, active low |
| cmd_in | input | 8 | Command byte presented during a write cycle |
| arr_data | input | 16 | Word from the memory array |
| dq_out | output | 16 | Data driven toward the bus, zero when not enabled |
| dq_oe | output | 1 | Data bus output enable (low means high-impedance) |
| ry_by | output | 1 | Ready (1) / busy (0) |
| lock_bits | output | NUM_BLOCKS | Per-block lock state |
| cmd_ignored | output | 1 | One-cycle flag: a command arrived inside the write wake-up window |

## Verification
The strobe decode is exercised with every combination that matters: a plain read, read strobe high, chip deselected with read strobe low, and a write cycle. This separates the output-enable gating of each pin. Device-reset pulses are tried both one edge short of RST_MIN and well beyond it, in both cases during a running operation. This shows the difference between an ignored glitch and an abort. After release, a read and a command write are each tried inside their own wake-up windows and again after them, which confirms that the two windows are timed independently. The lock-clear command is issued with write protect both low and high, and the operation length is measured with the chip deselected.

// File: rtl/nvm_bus_pkg.sv
package nvm_bus_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_WWRITE = 8'h40;
  localparam logic [7:0] CMD_UNLOCK = 8'h60;

  localparam logic [7:0] SR_IDLE = 8'h80;
  localparam logic [7:0] SR_BUSY = 8'h00;
endpackage

// File: rtl/nvm_rst_filter.sv
module nvm_rst_filter #(
  parameter int RST_MIN = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic in_rst,
  output logic qualify,
  output logic release_p
);
  localparam int CW = (RST_MIN < 2) ? 1 : $clog2(RST_MIN);
  localparam logic [CW-1:0] LIM = CW'(RST_MIN - 1);

  logic [CW-1:0] lo_q, lo_d;
  logic          in_rst_q, in_rst_d;

  always_comb begin
    qualify   = !pin_n && !in_rst_q && (lo_q == LIM);
    release_p = pin_n && in_rst_q;
    if (pin_n)            lo_d = '0;
    else if (lo_q == LIM) lo_d = lo_q;
    else                  lo_d = lo_q + 1'b1;
    if (in_rst_q) in_rst_d = !pin_n;
    else          in_rst_d = qualify;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      in_rst_q <= 1'b0;
    end else begin
      lo_q     <= lo_d;
      in_rst_q <= in_rst_d;
    end
  end

  assign in_rst = in_rst_q;

  AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rst_q) |-> !$past(pin_n)); // R6
endmodule

// File: rtl/nvm_wake_timer.sv
module nvm_wake_timer #(
  parameter int CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)             cnt_d = CW'(CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    finish = (cnt_q == CW'(1)) && !abort;
    if (abort)              cnt_d = '0;
    else if (start)         cnt_d = CW'(CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(abort) || $past(cnt_q) == CW'(1))); // R5
endmodule

// File: rtl/nvm_bus_ctrl.sv
module nvm_bus_ctrl
  import nvm_bus_pkg::*;
#(
  parameter int          RST_MIN    = 25,
  parameter int          RD_WAKE    = 38,
  parameter int          WR_WAKE    = 30,
  parameter int          OP_CYCLES  = 64,
  parameter int          NUM_BLOCKS = 8,
  parameter logic [15:0] ID_CODE    = 16'h5A17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic                  rst_pin_n,
  input  logic                  wp_n,
  input  logic [7:0]            cmd_in,
  input  logic [15:0]           arr_data,
  output logic [15:0]           dq_out,
  output logic                  dq_oe,
  output logic                  ry_by,
  output logic [NUM_BLOCKS-1:0] lock_bits,
  output logic                  cmd_ignored
);
  logic in_rst, qualify, release_p;
  logic rd_done, wr_done;
  logic op_busy, op_finish, op_start;

  rd_mode_e              mode_q, mode_d;
  logic [7:0]            sr_q, sr_d;
  logic [NUM_BLOCKS-1:0] lock_q, lock_d;
  logic                  abort_q, abort_d;
  logic                  ign_q, ign_d;
  logic                  cmd_wr, cmd_ok;
  logic [15:0]           rd_word;

  nvm_rst_filter #(.RST_MIN(RST_MIN)) u_rst_filter (
    .clk(clk), .rst_n(rst_n), .pin_n(rst_pin_n),
    .in_rst(in_rst), .qualify(qualify), .release_p(release_p)
  );

  nvm_wake_timer #(.CYC(RD_WAKE)) u_rd_wake (
    .clk(clk), .rst_n(rst_n), .load(release_p), .done(rd_done)
  );

  nvm_wake_timer #(.CYC(WR_WAKE)) u_wr_wake (
    .clk(clk), .rst_n(rst_n), .load(release_p), .done(wr_done)
  );

  nvm_op_timer #(.CYC(OP_CYCLES)) u_op_timer (
    .clk(clk), .rst_n(rst_n), .start(op_start), .abort(qualify),
    .busy(op_busy), .finish(op_finish)
  );

  // Command acceptance
  always_comb begin
    cmd_wr   = !ce_n && !we_n && rst_pin_n && !in_rst;
    cmd_ok   = cmd_wr && wr_done;
    op_start = 1'b0;
    if (cmd_ok && !op_busy) begin
      if (cmd_in == CMD_ERASE || cmd_in == CMD_WWRITE) op_start = 1'b1;
      if (cmd_in == CMD_UNLOCK && wp_n)                 op_start = 1'b1;
    end
  end

  // Next-state for mode, status, locks, abort and flag
  always_comb begin
    mode_d  = mode_q;
    sr_d    = sr_q;
    lock_d  = lock_q;
    abort_d = abort_q;
    ign_d   = cmd_wr && !wr_done;
    if (qualify && op_busy) abort_d = 1'b1;
    if (op_finish)          sr_d    = SR_IDLE;
    if (cmd_ok) begin
      case (cmd_in)
        CMD_ARRAY:  mode_d = RD_ARRAY;
        CMD_IDENT:  mode_d = RD_IDENT;
        CMD_STATUS: mode_d = RD_STATUS;
        default:    ;
      endcase
    end
    if (op_start) begin
      mode_d = RD_STATUS;
      sr_d   = SR_BUSY;
      if (cmd_in == CMD_UNLOCK) lock_d = '0;
    end
    if (release_p) begin
      mode_d  = RD_ARRAY;
      sr_d    = SR_IDLE;
      lock_d  = '1;
      abort_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= RD_ARRAY;
      sr_q    <= SR_IDLE;
      lock_q  <= '1;
      abort_q <= 1'b0;
      ign_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      sr_q    <= sr_d;
      lock_q  <= lock_d;
      abort_q <= abort_d;
      ign_q   <= ign_d;
    end
  end

  // Read path
  always_comb begin
    case (mode_q)
      RD_IDENT:  rd_word = ID_CODE;
      RD_STATUS: rd_word = {8'h00, sr_q};
      default:   rd_word = arr_data;
    endcase
    dq_oe  = !ce_n && !oe_n && we_n && rst_pin_n && !in_rst && rd_done;
    dq_out = dq_oe ? rd_word : 16'h0000;
  end

  assign ry_by       = !op_busy && !abort_q;
  assign lock_bits   = lock_q;
  assign cmd_ignored = ign_q;

  AST_OE_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && !oe_n && we_n && rst_pin_n)); // R2
  AST_RELEASE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rst) |-> (mode_q == RD_ARRAY && sr_q == SR_IDLE && (&lock_q))); // R7
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rst && abort_q) |-> !ry_by); // R8
  AST_RD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> !dq_oe); // R9
  AST_WR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ignored |-> ($past(cmd_wr) && !$past(wr_done))); // R10
  AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rst |-> (sr_q[7] == !op_busy)); // R11
endmodule

// File: tb/nvm_bus_ctrl_bench.sv
module nvm_bus_ctrl_bench;
  localparam int          RST_MIN = 25;
  localparam int          RD_WAKE = 38;
  localparam int          WR_WAKE = 30;
  localparam int          OPC     = 64;
  localparam int          NB      = 8;
  localparam logic [15:0] IDC     = 16'h5A17;
  localparam logic [15:0] ARR     = 16'hC3A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rst_pin_n = 1'b1, wp_n = 1'b1;
  logic [7:0]  cmd_in = 8'h00;
  logic [15:0] arr_data = ARR;
  logic [15:0] dq_out;
  logic        dq_oe, ry_by, cmd_ignored;
  logic [NB-1:0] lock_bits;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  nvm_bus_ctrl #(
    .RST_MIN(RST_MIN), .RD_WAKE(RD_WAKE), .WR_WAKE(WR_WAKE),
    .OP_CYCLES(OPC), .NUM_BLOCKS(NB), .ID_CODE(IDC)
  ) u_nvm_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rst_pin_n(rst_pin_n), .wp_n(wp_n), .cmd_in(cmd_in), .arr_data(arr_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by), .lock_bits(lock_bits),
    .cmd_ignored(cmd_ignored)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_mode, m_sr, m_busy, m_lo, m_rdw, m_wrw;
  bit m_abort, m_inrst, m_ign;
  logic [NB-1:0] m_locks;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sr = 8'h80; m_busy = 0; m_lo = 0; m_rdw = 0; m_wrw = 0;
      m_abort = 0; m_inrst = 0; m_ign = 0; m_locks = '1;
    end else begin
      bit cmd, qual, rel, accept, start;
      int busy_old;
      cmd      = !ce_n && !we_n && rst_pin_n && !m_inrst;
      accept   = cmd && (m_wrw == 0);
      qual     = !rst_pin_n && !m_inrst && (m_lo == RST_MIN - 1);
      rel      = rst_pin_n && m_inrst;
      busy_old = m_busy;
      m_ign    = cmd && (m_wrw != 0);
      if (rst_pin_n) m_lo = 0; else if (m_lo < RST_MIN - 1) m_lo++;
      if (qual) begin
        if (m_busy > 0) m_abort = 1;
        m_busy = 0; m_inrst = 1;
      end else if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) m_sr = 8'h80;
      end
      start = 0;
      if (accept) begin
        if (cmd_in == 8'hFF) m_mode = 0;
        if (cmd_in == 8'h90) m_mode = 1;
        if (cmd_in == 8'h70) m_mode = 2;
        if (busy_old == 0 && (cmd_in == 8'h20 || cmd_in == 8'h40)) start = 1;
        if (busy_old == 0 && cmd_in == 8'h60 && wp_n) begin start = 1; m_locks = '0; end
      end
      if (start) begin m_busy = OPC; m_sr = 8'h00; m_mode = 2; end
      if (m_rdw > 0) m_rdw--;
      if (m_wrw > 0) m_wrw--;
      if (rel) begin
        m_inrst = 0; m_abort = 0; m_mode = 0; m_sr = 8'h80; m_locks = '1;
        m_rdw = RD_WAKE; m_wrw = WR_WAKE;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_oe;
      logic [15:0] exp_dq;
      exp_oe = !ce_n && !oe_n && we_n && rst_pin_n && !m_inrst && (m_rdw == 0);
      exp_dq = !exp_oe ? 16'h0 : (m_mode == 1) ? IDC : (m_mode == 2) ? {8'h00, m_sr[7:0]} : arr_data;
      chk(32'(dq_oe), 32'(exp_oe), "R2 dq_oe");
      chk(32'(dq_out), 32'(exp_dq), "R11 dq_out");
      chk(32'(ry_by), 32'(m_busy == 0 && !m_abort), "R8 ry_by");
      chk(32'(cmd_ignored), 32'(m_ign), "R10 cmd_ignored");
      chk(32'(lock_bits), 32'(m_locks), "R7 lock_bits");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_cmd(input logic [7:0] c);
    @(negedge clk); #1;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; cmd_in = c;
    @(negedge clk); #1;
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd_set;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; #1;
  endtask

  task automatic idle_set;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; #1;
  endtask

  task automatic rst_pulse(input int edges);
    @(negedge clk); #1;
    rst_pin_n = 1'b0;
    repeat (edges) @(negedge clk);
    #1;
    rst_pin_n = 1'b1;
  endtask

  initial begin
    int cnt;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(32'(lock_bits), 32'({NB{1'b1}}), "R7 reset lock state");
    chk(32'(ry_by), 32'd1, "R5 ready after reset");
    // R1: array read without any command
    rd_set;
    chk(32'(dq_oe), 32'd1, "R1 output enabled");
    chk(32'(dq_out), 32'(ARR), "R1 array data");
    // R3: read strobe high
    oe_n = 1'b1; #1;
    chk(32'(dq_oe), 32'd0, "R3 oe high disables");
    chk(32'(dq_out), 32'd0, "R3 bus zero");
    // R4: deselected with read strobe low
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk(32'(dq_oe), 32'd0, "R4 standby");
    idle_set;
    // R11: identifier and status modes
    wr_cmd(8'h90); cyc(1); rd_set;
    chk(32'(dq_out), 32'(IDC), "R11 identifier");
    idle_set;
    wr_cmd(8'h70); cyc(1); rd_set;
    chk(32'(dq_out), 32'h0080, "R11 status idle");
    idle_set;
    wr_cmd(8'hFF); cyc(1); rd_set;
    chk(32'(dq_out), 32'(ARR), "R11 back to array");
    idle_set;
    // R12 + R5: erase, deselected for whole duration
    wr_cmd(8'h20);
    cnt = 0;
    while (ry_by == 1'b0 && cnt < OPC + 10) begin
      cnt++;
      cyc(1);
    end
    chk(32'(cnt), 32'(OPC), "R5 busy length with ce_n high");
    rd_set;
    chk(32'(dq_out), 32'h0080, "R12 status mode after op");
    idle_set;
    // R12: lock clear with write protect active is ignored
    wp_n = 1'b0;
    wr_cmd(8'h60); cyc(1);
    chk(32'(lock_bits), 32'({NB{1'b1}}), "R12 protected unlock ignored");
    chk(32'(ry_by), 32'd1, "R12 protected unlock no op");
    wp_n = 1'b1;
    wr_cmd(8'h60); cyc(1);
    chk(32'(lock_bits), 32'd0, "R12 unlock clears locks");
    chk(32'(ry_by), 32'd0, "R12 unlock busy");
    wr_cmd(8'h40); cyc(1);
    // R6: short reset pulse during operation
    rst_pulse(RST_MIN - 1); cyc(1);
    chk(32'(ry_by), 32'd0, "R6 op continues after glitch");
    chk(32'(lock_bits), 32'd0, "R6 locks untouched");
    rd_set;
    chk(32'(dq_oe), 32'd1, "R6 no wake window");
    idle_set;
    // R8: qualified reset aborts
    rst_pulse(RST_MIN + 5);
    chk(32'(ry_by), 32'd0, "R8 busy held until release");
    cyc(1);
    chk(32'(ry_by), 32'd1, "R8 ready after release");
    chk(32'(lock_bits), 32'({NB{1'b1}}), "R7 locks set on release");
    rd_set;
    chk(32'(dq_oe), 32'd0, "R9 read wake window");
    idle_set;
    // R10: command in write wake window
    wr_cmd(8'h90); #0;
    chk(32'(cmd_ignored), 32'd1, "R10 flag raised");
    cyc(1);
    chk(32'(cmd_ignored), 32'd0, "R10 flag one cycle");
    cyc(RD_WAKE + 2);
    rd_set;
    chk(32'(dq_oe), 32'd1, "R9 reads after wake");
    chk(32'(dq_out), 32'(ARR), "R10 ignored command left array mode");
    idle_set;
    cyc(WR_WAKE);
    wr_cmd(8'h70); cyc(1);
    chk(32'(cmd_ignored), 32'd0, "R10 accepted after window");
    rd_set;
    chk(32'(dq_out), 32'h0080, "R7 status 0x80 after reset");
    idle_set;
    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule